// File: doc/BRIEF.md
# Register Bank with Constant, Status, Stack and Program-Counter Entries

This block holds the working registers of a small CPU that fetches 16-bit instructions one byte at a time. It has sixteen 32-bit entries, two combinational read ports and one write port, which can write a full word or only the low byte. Some entries follow their own rules. Entries 0 and 1 are the constants zero and one. Entry 13 holds the status flags and the selected arithmetic operation, and its top bit can never be cleared. Entry 14 is the stack pointer and entry 15 is the program counter.

Beside the general write port there are three side channels. A flag-update strobe rewrites only the sign and zero bits of entry 13. Push and pop strobes move the stack pointer down or up by one stack slot. An increment strobe advances the program counter by one byte, and a load strobe replaces it. The surrounding sequencer issues each of these as a single-cycle strobe. There is no back-pressure on any pin: every strobe that is asserted on a rising clock edge takes effect on that edge. The result can be read on the read ports in the cycle that follows.

Top module: `regbank_top`

## Requirements
- R1: While reset is held and right after it is released, every entry reads 0, except entry 1, which reads 1, and entry 13, which reads 32'h8000_0000.
- R2: Entry 0 always reads 32'h0 and entry 1 always reads 32'h1. Writes to these two entries leave their read values unchanged.
- R3: Both read ports are combinational. A value written on a clock edge can be read on either port from the next cycle.
- R4: When `wr_low_only` is 1, a write changes only bits [7:0] of the target entry. Bits [31:8] keep their old value, and no sign extension takes place.
- R5: Bit 31 of entry 13 reads 1 at all times, including after a write that carries 0 in that bit.
- R6: A flag update with no write to entry 13 in the same cycle has three effects on entry 13. Bit 30 takes `flg_sign`, bit 29 takes `flg_zero`, and bits [28:0] stay unchanged.
- R7: A write to entry 13 in the same cycle as a flag update wins over the update. Bit 31 is then forced back to 1.
- R8: Each cycle, entry 14 changes according to the first rule below that applies:
  - A general write to entry 14 takes priority over push and pop.
  - A push alone subtracts 4.
  - A pop alone adds 4.
  - A push and a pop together leave entry 14 unchanged.
- R9: `pc_inc` alone adds 1 to entry 15.
- R10: For entry 15, the sources rank in this order: `pc_load` (value `pc_value`) first, then a general write, then `pc_inc`.
- R11: `alu_op` always shows bits [7:0] of entry 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_sel | input | 4 | Read port A entry index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_sel | input | 4 | Read port B entry index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General write strobe |
| wr_sel | input | 4 | General write entry index |
| wr_low_only | input | 1 | Write only bits [7:0] |
| wr_data | input | 32 | General write data |
| flg_en | input | 1 | Flag update strobe for entry 13 |
| flg_sign | input | 1 | New sign bit (bit 30) |
| flg_zero | input | 1 | New zero bit (bit 29) |
| sp_push | input | 1 | Decrement stack pointer by 4 |
| sp_pop | input | 1 | Increment stack pointer by 4 |
| pc_inc | input | 1 | Advance program counter by 1 |
| pc_load | input | 1 | Load program counter from `pc_value` |
| pc_value | input | 32 | Program counter load value |
| alu_op | output | 8 | Selected operation code, bits [7:0] of entry 13 |

## Verification
The collisions that matter are between the general write port and a side channel aimed at the same entry in the same cycle:
- a write to entry 13 during a flag update;
- a write to entry 14 during a push;
- a write to entry 15 during an increment or a load.

The bench drives both strobes on the same edge. On the next cycle it reads the entry back through a read port and compares it with the value the priority rules predict. It also drives push and pop together, and checks that the stack pointer ends up where it started.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned SEL_W      = 4;
  localparam int unsigned LOW_W      = 8;
  localparam int unsigned ZERO_IDX   = 0;
  localparam int unsigned ONE_IDX    = 1;
  localparam int unsigned FLAGS_IDX  = 13;
  localparam int unsigned SP_IDX     = 14;
  localparam int unsigned PC_IDX     = 15;
  localparam int unsigned HOLD_BIT   = 31;
  localparam int unsigned SIGN_BIT   = 30;
  localparam int unsigned ZFLAG_BIT  = 29;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t merge_write(input word_t old_v, input word_t new_v,
                                        input logic low_only);
    word_t r;
    r = low_only ? {old_v[WORD_W-1:LOW_W], new_v[LOW_W-1:0]} : new_v;
    return r;
  endfunction
endpackage

// File: rtl/regbank_word.sv
module regbank_word
  import regbank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_hit,
  input  logic  wr_low_only,
  input  word_t wr_data,
  output word_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (wr_hit) q <= merge_write(q, wr_data, wr_low_only);
  end

  // R3
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && !wr_low_only |=> q == $past(wr_data));
  // R4
  low_byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && wr_low_only |=> q[WORD_W-1:LOW_W] == $past(q[WORD_W-1:LOW_W])
                            && q[LOW_W-1:0] == $past(wr_data[LOW_W-1:0]));
endmodule

// File: rtl/regbank_flags.sv
module regbank_flags
  import regbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic             wr_low_only,
  input  word_t            wr_data,
  input  logic             flg_en,
  input  logic             flg_sign,
  input  logic             flg_zero,
  output word_t            flags_q,
  output logic [LOW_W-1:0] alu_op
);
  logic [WORD_W-2:0] low_q;
  word_t             nxt;

  assign flags_q = {1'b1, low_q};
  assign alu_op  = flags_q[LOW_W-1:0];

  always_comb begin
    nxt = flags_q;
    if (wr_hit) begin
      nxt = merge_write(flags_q, wr_data, wr_low_only);
    end else if (flg_en) begin
      nxt[SIGN_BIT]  = flg_sign;
      nxt[ZFLAG_BIT] = flg_zero;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= '0;
    else        low_q <= nxt[WORD_W-2:0];
  end

  // R6
  flag_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flg_en && !wr_hit |=> flags_q[SIGN_BIT] == $past(flg_sign)
                       && flags_q[ZFLAG_BIT] == $past(flg_zero)
                       && flags_q[ZFLAG_BIT-1:0] == $past(flags_q[ZFLAG_BIT-1:0]));
  // R7
  write_over_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && !wr_low_only && flg_en |=>
      flags_q == ($past(wr_data) | (word_t'(1) << HOLD_BIT)));
  // R5
  hold_bit_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> flags_q[HOLD_BIT]);
endmodule

// File: rtl/regbank_sp.sv
module regbank_sp
  import regbank_pkg::*;
#(
  parameter int unsigned STEP = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_hit,
  input  logic  wr_low_only,
  input  word_t wr_data,
  input  logic  push,
  input  logic  pop,
  output word_t sp_q
);
  localparam word_t STEP_W = word_t'(STEP);
  word_t nxt;

  always_comb begin
    nxt = sp_q;
    if (wr_hit)            nxt = merge_write(sp_q, wr_data, wr_low_only);
    else if (push && !pop) nxt = sp_q - STEP_W;
    else if (pop && !push) nxt = sp_q + STEP_W;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= nxt;
  end

  // R8
  push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop && !wr_hit |=> sp_q == $past(sp_q) - STEP_W);
  // R8
  pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && !wr_hit |=> sp_q == $past(sp_q) + STEP_W);
  // R8
  push_pop_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop && !wr_hit |=> $stable(sp_q));
  // R8
  write_over_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && !wr_low_only |=> sp_q == $past(wr_data));
endmodule

// File: rtl/regbank_pc.sv
module regbank_pc
  import regbank_pkg::*;
#(
  parameter int unsigned STEP = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_hit,
  input  logic  wr_low_only,
  input  word_t wr_data,
  input  logic  inc,
  input  logic  load,
  input  word_t load_value,
  output word_t pc_q
);
  localparam word_t STEP_W = word_t'(STEP);
  word_t nxt;

  always_comb begin
    nxt = pc_q;
    if (load)        nxt = load_value;
    else if (wr_hit) nxt = merge_write(pc_q, wr_data, wr_low_only);
    else if (inc)    nxt = pc_q + STEP_W;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= nxt;
  end

  // R9
  pc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !load && !wr_hit |=> pc_q == $past(pc_q) + STEP_W);
  // R10
  pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pc_q == $past(load_value));
  // R10
  pc_write_over_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load && wr_hit && !wr_low_only |=> pc_q == $past(wr_data));
endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned SP_STEP  = 4,
  parameter int unsigned PC_STEP  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SEL_W-1:0]        rd_a_sel,
  output logic [WORD_W-1:0]       rd_a_data,
  input  logic [SEL_W-1:0]        rd_b_sel,
  output logic [WORD_W-1:0]       rd_b_data,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic                    wr_low_only,
  input  logic [WORD_W-1:0]       wr_data,
  input  logic                    flg_en,
  input  logic                    flg_sign,
  input  logic                    flg_zero,
  input  logic                    sp_push,
  input  logic                    sp_pop,
  input  logic                    pc_inc,
  input  logic                    pc_load,
  input  logic [WORD_W-1:0]       pc_value,
  output logic [LOW_W-1:0]        alu_op
);
  word_t [NUM_REGS-1:0] regs_q;
  logic  [NUM_REGS-1:0] hit;

  always_comb begin
    hit = '0;
    if (wr_en) hit[wr_sel] = 1'b1;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    if (i == ZERO_IDX) begin : g_zero
      assign regs_q[i] = '0;
    end else if (i == ONE_IDX) begin : g_one
      assign regs_q[i] = word_t'(1);
    end else if (i == FLAGS_IDX) begin : g_flags
      regbank_flags u_flags (
        .clk(clk), .rst_n(rst_n), .wr_hit(hit[i]), .wr_low_only(wr_low_only),
        .wr_data(wr_data), .flg_en(flg_en), .flg_sign(flg_sign),
        .flg_zero(flg_zero), .flags_q(regs_q[i]), .alu_op(alu_op));
    end else if (i == SP_IDX) begin : g_sp
      regbank_sp #(.STEP(SP_STEP)) u_sp (
        .clk(clk), .rst_n(rst_n), .wr_hit(hit[i]), .wr_low_only(wr_low_only),
        .wr_data(wr_data), .push(sp_push), .pop(sp_pop), .sp_q(regs_q[i]));
    end else if (i == PC_IDX) begin : g_pc
      regbank_pc #(.STEP(PC_STEP)) u_pc (
        .clk(clk), .rst_n(rst_n), .wr_hit(hit[i]), .wr_low_only(wr_low_only),
        .wr_data(wr_data), .inc(pc_inc), .load(pc_load),
        .load_value(pc_value), .pc_q(regs_q[i]));
    end else begin : g_plain
      regbank_word u_word (
        .clk(clk), .rst_n(rst_n), .wr_hit(hit[i]), .wr_low_only(wr_low_only),
        .wr_data(wr_data), .q(regs_q[i]));
    end
  end

  assign rd_a_data = regs_q[rd_a_sel];
  assign rd_b_data = regs_q[rd_b_sel];

  // R2
  const_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_sel == SEL_W'(ZERO_IDX) |-> rd_a_data == '0);
  // R2
  const_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_sel == SEL_W'(ONE_IDX) |-> rd_b_data == word_t'(1));
  // R11
  alu_op_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_sel == SEL_W'(FLAGS_IDX) |-> alu_op == rd_a_data[LOW_W-1:0]);
  // R5
  hold_bit_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_sel == SEL_W'(FLAGS_IDX) |-> rd_b_data[HOLD_BIT]);
endmodule

// File: tb/regbank_top_test.sv
module regbank_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, pc_value = '0;
  logic        wr_en = 0, wr_low_only = 0, flg_en = 0, flg_sign = 0, flg_zero = 0;
  logic        sp_push = 0, sp_pop = 0, pc_inc = 0, pc_load = 0;
  logic [7:0]  alu_op;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  regbank_top uut (
    .clk(clk), .rst_n(rst_n), .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_low_only(wr_low_only), .wr_data(wr_data), .flg_en(flg_en),
    .flg_sign(flg_sign), .flg_zero(flg_zero), .sp_push(sp_push), .sp_pop(sp_pop),
    .pc_inc(pc_inc), .pc_load(pc_load), .pc_value(pc_value), .alu_op(alu_op));

  // {req[72:69], sel[68:65], low_only[64], data[63:32], expected[31:0]}
  localparam logic [72:0] VEC [10] = '{
    {4'd3,  4'd2,  1'b0, 32'h1234_5678, 32'h1234_5678},
    {4'd4,  4'd2,  1'b1, 32'hFFFF_FFAB, 32'h1234_56AB},
    {4'd3,  4'd12, 1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {4'd2,  4'd0,  1'b0, 32'hFFFF_FFFF, 32'h0000_0000},
    {4'd2,  4'd1,  1'b0, 32'h0000_0000, 32'h0000_0001},
    {4'd5,  4'd13, 1'b0, 32'h0000_0005, 32'h8000_0005},
    {4'd4,  4'd13, 1'b1, 32'h0000_00A7, 32'h8000_00A7},
    {4'd3,  4'd14, 1'b0, 32'h0000_1000, 32'h0000_1000},
    {4'd3,  4'd15, 1'b0, 32'h0000_0200, 32'h0000_0200},
    {4'd4,  4'd7,  1'b1, 32'h0000_0080, 32'h0000_0080}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic quiet();
    wr_en = 0; wr_low_only = 0; flg_en = 0; sp_push = 0; sp_pop = 0;
    pc_inc = 0; pc_load = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    quiet();
  endtask

  task automatic write(input logic [3:0] sel, input logic [31:0] d, input logic low);
    wr_en = 1; wr_sel = sel; wr_data = d; wr_low_only = low;
  endtask

  task automatic read_a(input logic [3:0] sel, output logic [31:0] v);
    rd_a_sel = sel;
    #1 v = rd_a_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    @(negedge clk);
    // R1: values while reset is held
    read_a(4'd1, v);  check("R1", v, 32'h1);
    read_a(4'd13, v); check("R1", v, 32'h8000_0000);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: every entry after reset release
    for (int i = 0; i < 16; i++) begin
      read_a(4'(i), v);
      check("R1", v, (i == 1) ? 32'h1 : (i == 13) ? 32'h8000_0000 : 32'h0);
    end

    for (int k = 0; k < 10; k++) begin
      write(VEC[k][68:65], VEC[k][63:32], VEC[k][64]);
      tick();
      read_a(VEC[k][68:65], v);
      check($sformatf("R%0d vec%0d portA", VEC[k][72:69], k), v, VEC[k][31:0]);
      rd_b_sel = VEC[k][68:65];
      #1 check($sformatf("R%0d vec%0d portB", VEC[k][72:69], k), rd_b_data, VEC[k][31:0]);
    end

    // R3: read ports follow selection without a clock edge
    read_a(4'd12, v); check("R3", v, 32'hDEAD_BEEF);
    // R11
    check("R11", {24'h0, alu_op}, 32'h0000_00A7);

    // R6: flag updates touch only bits 30 and 29
    flg_en = 1; flg_sign = 1; flg_zero = 0; tick();
    read_a(4'd13, v); check("R6", v, 32'hC000_00A7);
    flg_en = 1; flg_sign = 0; flg_zero = 1; tick();
    read_a(4'd13, v); check("R6", v, 32'hA000_00A7);

    // R7: general write wins over flag update, bit 31 re-forced
    flg_en = 1; flg_sign = 1; flg_zero = 1; write(4'd13, 32'h0000_0011, 0); tick();
    read_a(4'd13, v); check("R7", v, 32'h8000_0011);
    check("R11", {24'h0, alu_op}, 32'h0000_0011);
    // R5
    write(4'd13, 32'h0000_0000, 0); tick();
    read_a(4'd13, v); check("R5", v, 32'h8000_0000);

    // R8: stack pointer moves
    sp_push = 1; tick();
    read_a(4'd14, v); check("R8 push", v, 32'h0000_0FFC);
    sp_pop = 1; tick();
    read_a(4'd14, v); check("R8 pop", v, 32'h0000_1000);
    sp_push = 1; sp_pop = 1; tick();
    read_a(4'd14, v); check("R8 both", v, 32'h0000_1000);
    sp_push = 1; write(4'd14, 32'h0000_0040, 0); tick();
    read_a(4'd14, v); check("R8 write wins", v, 32'h0000_0040);

    // R9: program counter increments
    for (int j = 0; j < 3; j++) begin pc_inc = 1; tick(); end
    read_a(4'd15, v); check("R9", v, 32'h0000_0203);

    // R10: load beats write beats increment
    pc_load = 1; pc_value = 32'h0000_0800; pc_inc = 1; write(4'd15, 32'h55, 0); tick();
    read_a(4'd15, v); check("R10 load", v, 32'h0000_0800);
    pc_inc = 1; write(4'd15, 32'h0000_0300, 0); tick();
    read_a(4'd15, v); check("R10 write", v, 32'h0000_0300);

    // R2: constants after all activity
    rd_b_sel = 4'd1; read_a(4'd0, v);
    check("R2", v, 32'h0); check("R2", rd_b_data, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule